// File: doc/BRIEF.md
# Reset Sequencer with Debug-Halt Mode Select

This block orders the reset of a microcontroller core. When it accepts a reset cause, it pulls the shared open-drain reset pad low for a fixed number of clock cycles. It then lets the external or internal pull-up raise the pad and waits a set number of settle cycles. After that it reads the pad once, and the level it reads sets what happens next. A high pad following an internally generated power-on event counts as a power-on reset. A low pad counts as a reset held from outside the chip, and the sequencer waits for the pad to rise before it continues on the normal path.

A power-on classification also looks at the background-debug pad. When that pad is low, the core is held in debug-halt mode and no user code runs. In every other case the core gets a one-cycle request to fetch its reset vector. Debug-halt entry depends only on the internal power-on pulse and never on a rising edge at the reset pad. Both pads pass through two-flop synchronisers before any decision uses them. A three-bit cause register records why the last reset happened, and software clears its bits by writing ones.

Top module: `rst_sequencer`

## Requirements
- R1: After `rst_n` is released, `rst_pd_en_o`, `dbg_mode_o` and `fetch_o` are low and `sts_o` is 3'b000.
- R2: Accepting a cause (power-on pulse, internal request, or a synchronised low on the reset pad while running) drives `rst_pd_en_o` high for exactly DRIVE_CYC consecutive cycles (default 8).
- R3: SETTLE_CYC cycles after release, the pad is sampled once. If it is high and a power-on pulse started the sequence, the reset is classified as power-on and `sts_o[0]` is set.
- R4: A power-on classification with the background pad low raises `dbg_mode_o` and issues no `fetch_o` while `dbg_mode_o` is high.
- R5: Every classification that does not enter debug-halt ends in exactly one single-cycle `fetch_o` pulse.
- R6: A reset pad held low from outside while running sets `sts_o[1]` and never enters debug-halt, even with the background pad low.
- R7: If the pad is still low at the sample point, the block waits until it reads high and then takes the normal path. It sets `sts_o[1]` and leaves `sts_o[0]` clear, even when a power-on pulse started the sequence.
- R8: An internal reset request sets `sts_o[2]`.
- R9: Writing a one to bit n of `sts_clr_i` clears `sts_o[n]`. A zero has no effect. A cause set in the same cycle wins over the clear.
- R10: A power-on pulse or an internal request during any phase, including debug-halt, restarts the pull-down phase with a full DRIVE_CYC count.
- R11: `dbg_exit_i` during debug-halt drops `dbg_mode_o` and issues one `fetch_o` pulse in the same cycle. Outside debug-halt it has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_pulse_i | input | 1 | Internal power-on event pulse |
| int_req_i | input | 1 | Internal reset request pulse |
| rst_pin_i | input | 1 | Raw level of the reset pad |
| bkgd_pin_i | input | 1 | Raw level of the background-debug pad |
| dbg_exit_i | input | 1 | Leave debug-halt, from the debug interface |
| sts_clr_i | input | 3 | Write-one-to-clear strobes for the cause bits |
| rst_pd_en_o | output | 1 | Enables the reset pad pull-down |
| sts_o | output | 3 | Cause bits: [0] power-on, [1] external, [2] internal request |
| dbg_mode_o | output | 1 | Core held in debug-halt |
| fetch_o | output | 1 | One-cycle reset-vector fetch request |

## Verification
A wrong counter or state in this block shows at the ports as a pull-down pulse of the wrong length. It can also show as a fetch request where debug-halt was expected, or the reverse. Each of these is visible within DRIVE_CYC plus SETTLE_CYC plus two synchroniser cycles of the cause. A stale power-on pending flag shows as a wrong `sts_o[0]` value, or as an unintended debug-halt entry on a later reset. The bench measures pull-down width by counting cycles and checks the outcome and cause bits for each classification path. It also checks that restarts lengthen the pull-down by exactly the cycles already spent in it.

// File: rtl/rstseq_pkg.sv
// Shared types and cause-bit positions for the reset sequencer.
// Assumes: cause register is three bits wide, one bit per reset cause.
package rstseq_pkg;
    localparam int CAUSE_W   = 3;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_INT = 2;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_DRIVE  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_WAITHI = 3'd3,
        ST_DEBUG  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
// Two-flop synchroniser for a vector of independent pad levels.
// Assumes: each bit is a slow level; per-bit reset values come from RST_VAL.
module rstseq_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[b];
                    stab_q <= RST_VAL[b];
                end else begin
                    meta_q <= d_i[b];
                    stab_q <= meta_q;
                end
            end
            assign q_o[b] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/rstseq_status.sv
// Cause register: sticky bits set by the sequencer, cleared by writing ones.
// Assumes: set and clear arrive as single-cycle strobes; set wins over clear.
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output logic [CAUSE_W-1:0] sts_o
);
    logic [CAUSE_W-1:0] sts_q;

    // Update sticky cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_i) | set_i;
    end

    assign sts_o = sts_q;

    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rstseq_fsm.sv
// Reset phase controller: pull-down, settle, classify, debug-halt or fetch.
// Assumes: pad inputs are already synchronised; SETTLE_CYC covers the pull-up
// rise time plus the two synchroniser stages (at least 3).
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC  = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_i,
    input  logic               ireq_i,
    input  logic               pin_s_i,
    input  logic               bkgd_s_i,
    input  logic               dbg_exit_i,
    output logic               pd_o,
    output logic               dbg_o,
    output logic               fetch_o,
    output logic [CAUSE_W-1:0] cause_set_o
);
    localparam int CNT_MAX = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_e         st_q, st_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic               pend_q, pend_n;
    logic               pd_q, dbg_q, fetch_q;
    logic               fetch_n;
    logic [CAUSE_W-1:0] set_n;

    // Next-state, counter, pending flag and cause strobes.
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        pend_n  = pend_q;
        fetch_n = 1'b0;
        set_n   = '0;
        if (por_i || ireq_i) begin
            st_n  = ST_DRIVE;
            cnt_n = '0;
            if (por_i)  pend_n = 1'b1;
            if (ireq_i) set_n[CAUSE_INT] = 1'b1;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (!pin_s_i) begin
                        st_n  = ST_DRIVE;
                        cnt_n = '0;
                        set_n[CAUSE_EXT] = 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (cnt_q == DRV_LAST) begin
                        st_n  = ST_SETTLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q != SET_LAST) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (!pin_s_i) begin
                        st_n   = ST_WAITHI;
                        pend_n = 1'b0;
                        set_n[CAUSE_EXT] = 1'b1;
                    end else if (pend_q) begin
                        pend_n = 1'b0;
                        set_n[CAUSE_POR] = 1'b1;
                        if (!bkgd_s_i) begin
                            st_n = ST_DEBUG;
                        end else begin
                            st_n    = ST_RUN;
                            fetch_n = 1'b1;
                        end
                    end else begin
                        st_n    = ST_RUN;
                        fetch_n = 1'b1;
                    end
                end
                ST_WAITHI: begin
                    if (pin_s_i) begin
                        st_n    = ST_RUN;
                        fetch_n = 1'b1;
                    end
                end
                ST_DEBUG: begin
                    if (dbg_exit_i) begin
                        st_n    = ST_RUN;
                        fetch_n = 1'b1;
                    end else if (!pin_s_i) begin
                        st_n  = ST_DRIVE;
                        cnt_n = '0;
                        set_n[CAUSE_EXT] = 1'b1;
                    end
                end
                default: st_n = ST_RUN;
            endcase
        end
    end

    // State registers and registered pad/mode outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            pd_q    <= 1'b0;
            dbg_q   <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            pend_q  <= pend_n;
            pd_q    <= (st_n == ST_DRIVE);
            dbg_q   <= (st_n == ST_DEBUG);
            fetch_q <= fetch_n;
        end
    end

    assign pd_o        = pd_q;
    assign dbg_o       = dbg_q;
    assign fetch_o     = fetch_q;
    assign cause_set_o = set_n;

    // R2
    drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> ($past(cnt_q) == DRV_LAST));

    // R4
    no_fetch_in_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_q |-> !fetch_q);

    // R5
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_q |=> !fetch_q);

    // R6
    dbg_needs_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_q) |-> $past(pend_q));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_i || ireq_i) |=> (pd_q && cnt_q == '0));
endmodule

// File: rtl/rst_sequencer.sv
// Top of the reset sequencer: pad synchronisers, phase controller, cause register.
// Assumes: rst_pin_i and bkgd_pin_i are asynchronous pad levels; the reset pad
// has a pull-up and idles high; por_pulse_i and int_req_i are synchronous pulses.
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYC  = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_pulse_i,
    input  logic               int_req_i,
    input  logic               rst_pin_i,
    input  logic               bkgd_pin_i,
    input  logic               dbg_exit_i,
    input  logic [CAUSE_W-1:0] sts_clr_i,
    output logic               rst_pd_en_o,
    output logic [CAUSE_W-1:0] sts_o,
    output logic               dbg_mode_o,
    output logic               fetch_o
);
    logic [1:0]         pads_s;
    logic [CAUSE_W-1:0] cause_set;

    rstseq_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bkgd_pin_i, rst_pin_i}),
        .q_o   (pads_s)
    );

    rstseq_fsm #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_i       (por_pulse_i),
        .ireq_i      (int_req_i),
        .pin_s_i     (pads_s[0]),
        .bkgd_s_i    (pads_s[1]),
        .dbg_exit_i  (dbg_exit_i),
        .pd_o        (rst_pd_en_o),
        .dbg_o       (dbg_mode_o),
        .fetch_o     (fetch_o),
        .cause_set_o (cause_set)
    );

    rstseq_status u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cause_set),
        .clr_i (sts_clr_i),
        .sts_o (sts_o)
    );
endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
    localparam int D = 8;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0, ireq = 1'b0, bkgd = 1'b1, dexit = 1'b0, ext_hold = 1'b0;
    logic [2:0] clr = 3'b000;
    logic       pd, dbg, fetch;
    logic [2:0] sts;
    logic       pin;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    assign pin = !(pd || ext_hold);

    rst_sequencer #(.DRIVE_CYC(D), .SETTLE_CYC(S)) uut (
        .clk(clk), .rst_n(rst_n), .por_pulse_i(por), .int_req_i(ireq),
        .rst_pin_i(pin), .bkgd_pin_i(bkgd), .dbg_exit_i(dexit),
        .sts_clr_i(clr), .rst_pd_en_o(pd), .sts_o(sts),
        .dbg_mode_o(dbg), .fetch_o(fetch)
    );

    always #2 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_evt(input bit is_por);
        @(negedge clk);
        if (is_por) por = 1'b1; else ireq = 1'b1;
        @(negedge clk);
        por = 1'b0; ireq = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr = 3'b111;
        @(negedge clk); clr = 3'b000;
    endtask

    // Walk negedges until a fetch or debug entry; count pull-down cycles.
    task automatic observe(input int rel_at, output int pd_cnt,
                           output bit got_dbg, output bit got_fetch);
        pd_cnt = 0; got_dbg = 0; got_fetch = 0;
        for (int i = 0; i < 400; i++) begin
            if (ext_hold && i == rel_at) ext_hold = 1'b0;
            if (pd) pd_cnt++;
            if (fetch) begin got_fetch = 1; break; end
            if (dbg) begin got_dbg = 1; break; end
            @(negedge clk);
        end
    endtask

    // {is_por, bkgd, hold, exp_dbg, exp_sts[2:0]}
    localparam logic [6:0] VEC [6] = '{
        7'b1_0_0_1_001,
        7'b1_1_0_0_001,
        7'b0_0_0_0_100,
        7'b0_1_0_0_100,
        7'b1_0_1_0_010,
        7'b0_0_1_0_110
    };

    initial begin
        int pc;
        bit gd, gf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pd == 0 && dbg == 0 && fetch == 0, "R1 outputs idle", {pd, dbg, fetch}, 0);
        chk(sts == 3'b000, "R1 status clear", sts, 0);

        for (int v = 0; v < 6; v++) begin
            clear_all();
            bkgd = VEC[v][5];
            @(negedge clk);
            if (VEC[v][4]) ext_hold = 1'b1;
            if (VEC[v][6]) por = 1'b1; else ireq = 1'b1;
            @(negedge clk);
            por = 1'b0; ireq = 1'b0;
            observe(D + 20, pc, gd, gf);
            chk(pc == D, "R2 pull-down width", pc, D);
            chk(gd == VEC[v][3], "R4/R6/R7 debug outcome", gd, VEC[v][3]);
            chk(gf == !VEC[v][3], "R5 fetch outcome", gf, !VEC[v][3]);
            @(negedge clk);
            // R3 R7 R8 cause bits
            chk(sts == VEC[v][2:0], "R3/R7/R8 cause bits", sts, VEC[v][2:0]);
            if (gd) begin
                int fc = 0;
                for (int k = 0; k < 10; k++) begin
                    if (fetch || !dbg) fc++;
                    @(negedge clk);
                end
                chk(fc == 0, "R4 halted, no fetch", fc, 0);
                dexit = 1'b1;
                @(negedge clk);
                dexit = 1'b0;
                chk(fetch == 1 && dbg == 0, "R11 exit fetch", {fetch, dbg}, 2);
                @(negedge clk);
                chk(fetch == 0, "R5 fetch single cycle", fetch, 0);
            end else begin
                chk(fetch == 0, "R5 fetch single cycle", fetch, 0);
            end
            repeat (3) @(negedge clk);
        end

        // R6 external low from run, background low: no debug
        clear_all();
        bkgd = 1'b0;
        @(negedge clk);
        ext_hold = 1'b1;
        observe(6, pc, gd, gf);
        chk(pc == D && gf && !gd, "R6 external reset normal path", {gd, gf}, 1);
        @(negedge clk);
        chk(sts == 3'b010, "R6 external cause", sts, 2);

        // R10 restart during pull-down
        clear_all();
        bkgd = 1'b1;
        pulse_evt(1'b1);
        pc = pd ? 1 : 0;
        @(negedge clk); if (pd) pc++;
        @(negedge clk); if (pd) pc++;
        ireq = 1'b1;
        @(negedge clk);
        ireq = 1'b0;
        begin
            int pc2;
            observe(1000, pc2, gd, gf);
            chk(pc + pc2 == 3 + D, "R10 restart lengthens pull-down", pc + pc2, 3 + D);
        end
        @(negedge clk);
        chk(sts == 3'b101, "R10 both causes", sts, 5);

        // R9 clear one bit, zero write, set wins
        @(negedge clk); clr = 3'b001;
        @(negedge clk); clr = 3'b000;
        chk(sts == 3'b100, "R9 clear power-on bit only", sts, 4);
        @(negedge clk);
        chk(sts == 3'b100, "R9 zero write no effect", sts, 4);
        clr = 3'b100; ireq = 1'b1;
        @(negedge clk);
        clr = 3'b000; ireq = 1'b0;
        chk(sts[2] == 1'b1, "R9 set wins over clear", sts[2], 1);
        observe(1000, pc, gd, gf);
        chk(gf, "R5 fetch after internal request", gf, 1);

        // R10 power-on during debug-halt restarts
        repeat (2) @(negedge clk);
        clear_all();
        bkgd = 1'b0;
        pulse_evt(1'b1);
        observe(1000, pc, gd, gf);
        chk(gd, "R4 debug entered", gd, 1);
        bkgd = 1'b1;
        repeat (3) @(negedge clk);
        pulse_evt(1'b1);
        chk(pd == 1 && dbg == 0, "R10 restart from debug", {pd, dbg}, 2);
        observe(1000, pc, gd, gf);
        chk(gf && !gd, "R10 fetch after restart", {gd, gf}, 1);

        // R11 exit input ignored while running
        repeat (3) @(negedge clk);
        begin
            int bad = 0;
            dexit = 1'b1;
            @(negedge clk);
            dexit = 1'b0;
            for (int k = 0; k < 5; k++) begin
                if (fetch || dbg || pd) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R11 exit ignored outside debug", bad, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule